// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This block moves outgoing packet data from memory onto a word-wide stream. Software builds a singly linked chain of four-word descriptors in memory, each pointing at one buffer, and hands the chain to the engine by writing the address of its first descriptor into the head register. The engine reads each descriptor and confirms that the hardware-ownership flag is set. It then reads the buffer one 32-bit word at a time and presents each word on a valid/ready stream with a byte-valid mask, a packet-end flag and an optional destination-port tag. Finally it writes the descriptor's control word back with ownership returned to software.

A chain ends at a descriptor whose next pointer is zero. The engine marks that descriptor with an end-of-queue flag, clears the head register and stops. The flag tells software that any descriptor appended to the chain after the engine passed its tail was not seen, and that the engine must be restarted by writing the head register again. Software reports which descriptors it has reclaimed by writing their addresses into a completion register. Memory is reached through a simple request port whose read data comes back a fixed number of cycles later, with a valid strobe.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the engine is idle (`busy` low, `tx_valid` low, no memory request), and the control, head, completion and status registers (register addresses 0, 1, 2, 3) all read zero.
- R2: A write of a nonzero value to the head register (address 1) starts the engine at that byte address, but only when the enable bit (control bit 0) is set and the engine is idle. A write of zero, a write while disabled, and a write while busy are all ignored: the head register keeps its value and nothing starts.
- R3: A descriptor is fetched as four word reads at its address plus 0, 4, 8 and 12. The words are the next pointer, the buffer address, the buffer length (low 11 bits, in bytes) and the control word. Only one read is outstanding at a time.
- R4: If control-word bit 29 (hardware owns) of a fetched descriptor is clear, the engine returns to idle without streaming and without writing to memory. The head register then keeps that descriptor's address.
- R5: An owned descriptor of length L produces ceil(L/4) stream beats carrying the buffer's words in ascending address order. A length of zero produces no beat.
- R6: Every beat except the descriptor's final one has byte mask 4'hF. The final beat has mask 4'hF when L mod 4 is 0, and otherwise has only its low (L mod 4) bits set.
- R7: `tx_last` is high on a descriptor's final beat exactly when control-word bit 30 (packet end) is set, and is low on every other beat.
- R8: When control-word bit 20 is set, `tx_port_en` is high and `tx_port` carries control-word bits 18:16 during the descriptor's beats. When bit 20 is clear, both are zero.
- R9: After its beats, each owned descriptor's control word (address plus 12) is written back with bit 29 cleared and all other bits kept. `desc_done` pulses for exactly one cycle per descriptor.
- R10: If the next pointer is nonzero, the engine loads it into the head register and fetches it. If it is zero, the write-back also sets bit 28 (end of queue), the head register becomes zero and the engine goes idle.
- R11: The completion register (address 2) holds the last value software wrote to it. The engine never changes it.
- R12: A control write with bit 1 set aborts any transfer at that clock edge. The engine is idle by the next cycle, the head and completion registers and the enable bit are zero, and bit 1 reads back as zero.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_keep` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 head, 2 completion, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, accepted every cycle |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Read data valid, a fixed latency after the read request |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream beat valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 32 | Stream beat data |
| tx_keep | output | 4 | Byte-valid mask of the beat |
| tx_last | output | 1 | Final beat of a packet |
| tx_port_en | output | 1 | Destination port tag is valid |
| tx_port | output | 3 | Destination port tag |
| desc_done | output | 1 | One-cycle pulse per completed descriptor |
| busy | output | 1 | Engine is walking a chain |

## Verification
Single descriptors are swept over every length from 0 to 12 bytes. This covers all four byte-mask remainders, the zero-length case and beat counts from one to three, and alternates the port tag and stream backpressure so that a sideband or hold error shows up apart from a data error. Three-descriptor chains separate the per-descriptor final beat from the packet-end flag, and show that the end-of-queue flag marks only the tail. A chain that stops at an unowned second descriptor shows the stop leaving memory and the head register alone. Head writes that are disabled, zero or made while busy, and a soft reset in mid-packet, check the control paths against the stream and the register read-back.

// File: rtl/txd_pkg.sv
// Shared constants and types for the transmit descriptor DMA engine.
// Assumes 32-bit descriptor words and 32-bit stream beats.
package txd_pkg;
    // Control-word bit positions (decoded by software and hardware alike)
    localparam int MB_SOP     = 31;
    localparam int MB_EOP     = 30;
    localparam int MB_OWN     = 29;
    localparam int MB_EOQ     = 28;
    localparam int MB_PEN     = 20;
    localparam int MB_PORT_LO = 16;
    localparam int PORT_W     = 3;
    localparam int LEN_W      = 11;

    // Control register bits
    localparam int CB_EN   = 0;
    localparam int CB_SRST = 1;

    // Register addresses
    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_HEAD = 2'd1;
    localparam logic [1:0] RA_DONE = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_BRD,
        ST_BOUT,
        ST_WB
    } eng_state_t;

    // Byte mask of a final beat given the length remainder
    function automatic logic [3:0] tail_keep(input logic [1:0] rem);
        tail_keep = (rem == 2'd0) ? 4'hF : ((4'h1 << rem) - 4'h1);
    endfunction
endpackage

// File: rtl/txd_regs.sv
// Register file of the transmit descriptor DMA engine: enable bit,
// self-clearing soft reset, head pointer and completion pointer.
// Assumes the engine only reports head updates while busy.
module txd_regs
    import txd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          eng_busy,
    input  logic          hp_upd,
    input  logic [AW-1:0] hp_val,
    output logic          start,
    output logic [AW-1:0] start_addr,
    output logic          flush
);
    logic          ena_q;
    logic [AW-1:0] head_q;
    logic [AW-1:0] cp_q;
    logic          wr_ctrl;
    logic          wr_head;
    logic          wr_cp;

    assign wr_ctrl    = reg_wr && (reg_addr == RA_CTRL);
    assign wr_head    = reg_wr && (reg_addr == RA_HEAD);
    assign wr_cp      = reg_wr && (reg_addr == RA_DONE);
    assign flush      = wr_ctrl && reg_wdata[CB_SRST];
    assign start_addr = reg_wdata[AW-1:0];
    assign start      = wr_head && ena_q && !eng_busy && (reg_wdata[AW-1:0] != '0);

    // Register state: soft reset wins, then software writes and engine updates
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ena_q  <= 1'b0;
            head_q <= '0;
            cp_q   <= '0;
        end else begin
            if (wr_ctrl) ena_q <= reg_wdata[CB_EN];
            if (start) head_q <= start_addr;
            else if (hp_upd) head_q <= hp_val;
            if (wr_cp) cp_q <= reg_wdata[AW-1:0];
        end
    end

    // Read multiplexer
    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {31'b0, ena_q};
            RA_HEAD: reg_rdata = 32'(head_q);
            RA_DONE: reg_rdata = 32'(cp_q);
            default: reg_rdata = {31'b0, eng_busy};
        endcase
    end

    assert_flush_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!ena_q && head_q == '0 && cp_q == '0));

    assert_busy_head_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_head && eng_busy && !hp_upd && !flush) |=> $stable(head_q));
endmodule

// File: rtl/txd_engine.sv
// Descriptor walker and buffer streamer. Fetches four descriptor words,
// checks ownership, streams the buffer one word per read, writes the
// control word back and follows the next pointer.
// Assumes one read outstanding and memory that accepts every request.
module txd_engine
    import txd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic              flush,
    output logic              busy,
    output logic              hp_upd,
    output logic [AW-1:0]     hp_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic [3:0]        tx_keep,
    output logic              tx_last,
    output logic              tx_port_en,
    output logic [PORT_W-1:0] tx_port,
    output logic              desc_done
);
    localparam int CNT_W = LEN_W - 1;

    eng_state_t        st_q;
    logic              pend_q;
    logic [1:0]        fidx_q;
    logic [AW-1:0]     cur_q;
    logic [AW-1:0]     nxt_q;
    logic [AW-1:0]     buf_q;
    logic [LEN_W-1:0]  len_q;
    logic [31:0]       mode_q;
    logic [CNT_W-1:0]  bidx_q;
    logic [31:0]       dat_q;
    logic [LEN_W:0]    len_up;
    logic [CNT_W-1:0]  nbeats_m1;
    logic              last_beat;
    logic [31:0]       wb_word;

    assign len_up    = {1'b0, len_q} + (LEN_W+1)'(3);
    assign nbeats_m1 = CNT_W'((len_up >> 2) - 1);
    assign last_beat = (bidx_q == nbeats_m1);

    // Write-back word: ownership returned, end of queue on the tail
    always_comb begin
        wb_word         = mode_q;
        wb_word[MB_OWN] = 1'b0;
        if (nxt_q == '0) wb_word[MB_EOQ] = 1'b1;
    end

    // Memory request generation per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st_q)
            ST_FETCH: if (!pend_q) begin
                mem_req  = 1'b1;
                mem_addr = cur_q + AW'({fidx_q, 2'b00});
            end
            ST_BRD: if (!pend_q) begin
                mem_req  = 1'b1;
                mem_addr = buf_q + AW'({bidx_q, 2'b00});
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + AW'(12);
                mem_wdata = wb_word;
            end
            default: ;
        endcase
    end

    // Stream and status outputs
    assign tx_valid   = (st_q == ST_BOUT);
    assign tx_data    = dat_q;
    assign tx_keep    = last_beat ? tail_keep(len_q[1:0]) : 4'hF;
    assign tx_last    = last_beat && mode_q[MB_EOP];
    assign tx_port_en = mode_q[MB_PEN];
    assign tx_port    = mode_q[MB_PEN] ? mode_q[MB_PORT_LO +: PORT_W] : '0;
    assign desc_done  = (st_q == ST_WB);
    assign busy       = (st_q != ST_IDLE);
    assign hp_upd     = (st_q == ST_WB);
    assign hp_val     = nxt_q;

    // Walker state machine
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            st_q   <= ST_IDLE;
            pend_q <= 1'b0;
            fidx_q <= '0;
            bidx_q <= '0;
            cur_q  <= '0;
            nxt_q  <= '0;
            buf_q  <= '0;
            len_q  <= '0;
            mode_q <= '0;
            dat_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    cur_q  <= start_addr;
                    fidx_q <= '0;
                    st_q   <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (!pend_q) begin
                        pend_q <= 1'b1;
                    end else if (mem_rvalid) begin
                        pend_q <= 1'b0;
                        case (fidx_q)
                            2'd0: nxt_q  <= mem_rdata[AW-1:0];
                            2'd1: buf_q  <= mem_rdata[AW-1:0];
                            2'd2: len_q  <= mem_rdata[LEN_W-1:0];
                            default: mode_q <= mem_rdata;
                        endcase
                        fidx_q <= fidx_q + 2'd1;
                        if (fidx_q == 2'd3) st_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!mode_q[MB_OWN]) st_q <= ST_IDLE;
                    else if (len_q == '0) st_q <= ST_WB;
                    else begin
                        bidx_q <= '0;
                        st_q   <= ST_BRD;
                    end
                end
                ST_BRD: begin
                    if (!pend_q) begin
                        pend_q <= 1'b1;
                    end else if (mem_rvalid) begin
                        pend_q <= 1'b0;
                        dat_q  <= mem_rdata;
                        st_q   <= ST_BOUT;
                    end
                end
                ST_BOUT: if (tx_ready) begin
                    if (last_beat) st_q <= ST_WB;
                    else begin
                        bidx_q <= bidx_q + 1'b1;
                        st_q   <= ST_BRD;
                    end
                end
                ST_WB: begin
                    if (nxt_q == '0) st_q <= ST_IDLE;
                    else begin
                        cur_q  <= nxt_q;
                        fidx_q <= '0;
                        st_q   <= ST_FETCH;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assert_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !mem_rvalid) |-> !mem_req);

    assert_hold_beat_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !flush) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_keep) && $stable(tx_last)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |=> !desc_done);

    assert_keep_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_keep != 4'h0));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_valid && !mem_req));
endmodule

// File: rtl/txdesc_dma.sv
// Top of the transmit descriptor DMA engine: register file plus walker.
// Assumes word-aligned descriptor and buffer addresses.
module txdesc_dma
    import txd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic [3:0]        tx_keep,
    output logic              tx_last,
    output logic              tx_port_en,
    output logic [PORT_W-1:0] tx_port,
    output logic              desc_done,
    output logic              busy
);
    logic          start;
    logic [AW-1:0] start_addr;
    logic          flush;
    logic          hp_upd;
    logic [AW-1:0] hp_val;

    txd_regs #(.AW(AW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .eng_busy   (busy),
        .hp_upd     (hp_upd),
        .hp_val     (hp_val),
        .start      (start),
        .start_addr (start_addr),
        .flush      (flush)
    );

    txd_engine #(.AW(AW)) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .flush      (flush),
        .busy       (busy),
        .hp_upd     (hp_upd),
        .hp_val     (hp_val),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data),
        .tx_keep    (tx_keep),
        .tx_last    (tx_last),
        .tx_port_en (tx_port_en),
        .tx_port    (tx_port),
        .desc_done  (desc_done)
    );
endmodule

// File: tb/txdesc_dma_tb_top.sv
module txdesc_dma_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] OWN = 32'h2000_0000;
    localparam logic [31:0] SOP = 32'h8000_0000;
    localparam logic [31:0] EOP = 32'h4000_0000;
    localparam logic [31:0] EOQ = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        tx_valid, tx_ready, tx_last, tx_port_en, desc_done, busy;
    logic [31:0] tx_data;
    logic [3:0]  tx_keep;
    logic [2:0]  tx_port;

    always #(CLK_PERIOD/2) clk = ~clk;

    txdesc_dma dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_keep(tx_keep),
        .tx_last(tx_last), .tx_port_en(tx_port_en), .tx_port(tx_port),
        .desc_done(desc_done), .busy(busy)
    );

    function automatic logic [31:0] fpat(input int i);
        fpat = {8'(i), 8'(i * 3 + 1), 8'(255 - i), 8'(i ^ 90)};
    endfunction

    function automatic logic [3:0] kexp(input int len, input bit fin);
        if (!fin || (len % 4) == 0) kexp = 4'hF;
        else kexp = 4'((1 << (len % 4)) - 1);
    endfunction

    // Memory model: two-cycle read latency, bench preload port
    logic [31:0] mem [0:255];
    logic        s1_v, s2_v;
    logic [7:0]  s1_a;
    logic [31:0] s2_d;
    logic        tb_we;
    logic [31:0] tb_wa, tb_wd;
    logic [31:0] rd_a [0:4095];
    int          nrd;
    assign mem_rvalid = s2_v;
    assign mem_rdata  = s2_d;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= fpat(i);
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            nrd  <= 0;
        end else begin
            s1_v <= mem_req && !mem_we;
            s1_a <= mem_addr[9:2];
            s2_v <= s1_v;
            s2_d <= mem[s1_a];
            if (mem_req && !mem_we && nrd < 4096) begin
                rd_a[nrd] <= mem_addr;
                nrd <= nrd + 1;
            end
            if (tb_we) mem[tb_wa[9:2]] <= tb_wd;
            else if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        end
    end

    // Sink backpressure pattern
    logic [7:0] cyc = 8'd0;
    logic       bp_on;
    always @(posedge clk) cyc <= cyc + 8'd1;
    assign tx_ready = !bp_on || (cyc[0] ^ cyc[2]);

    // Monitor: beats, done pulses, hold under stall
    logic [31:0] bt_d [0:511];
    logic [3:0]  bt_k [0:511];
    logic        bt_l [0:511];
    logic [3:0]  bt_p [0:511];
    int          nbt = 0, ndone = 0, nstall = 0, nhold_bad = 0;
    logic        stall_prev = 1'b0;
    logic [31:0] prev_d;
    logic [3:0]  prev_k;
    logic        prev_l;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready && nbt < 512) begin
                bt_d[nbt] <= tx_data;
                bt_k[nbt] <= tx_keep;
                bt_l[nbt] <= tx_last;
                bt_p[nbt] <= {tx_port_en, tx_port};
                nbt <= nbt + 1;
            end
            if (desc_done) ndone <= ndone + 1;
            if (stall_prev) begin
                nstall <= nstall + 1;
                if (!(tx_valid && tx_data == prev_d && tx_keep == prev_k && tx_last == prev_l))
                    nhold_bad <= nhold_bad + 1;
            end
            stall_prev <= tx_valid && !tx_ready;
            prev_d <= tx_data;
            prev_k <= tx_keep;
            prev_l <= tx_last;
        end
    end

    int ntot = 0, nfail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic mem_put(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = a; tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] bf,
                            input logic [31:0] ln, input logic [31:0] md);
        mem_put(a, nx);
        mem_put(a + 4, bf);
        mem_put(a + 8, ln);
        mem_put(a + 12, md);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", ntot - nfail, ntot + 1);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [31:0] md;
        int base_b, base_d, base_r, nb, bw;
        int ln_c [3];
        int bw_c [3];
        logic [31:0] md_c [3];
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        tb_we = 1'b0; tb_wa = '0; tb_wd = '0; bp_on = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !tx_valid && !mem_req, "R1 idle outputs", {busy, tx_valid, mem_req}, 0);
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), rv);
            chk(rv == 0, "R1 register read", rv, 0);
        end

        // R2 head write while disabled is ignored
        put_desc(32'h100, 0, 32'h200, 8, OWN | SOP | EOP | 8);
        base_b = nbt;
        reg_write(2'd1, 32'h100);
        repeat (10) @(negedge clk);
        chk(!busy && nbt == base_b, "R2 disabled start", 32'(nbt - base_b), 0);
        reg_read(2'd1, rv);
        chk(rv == 0, "R2 head while disabled", rv, 0);
        reg_write(2'd0, 1);
        reg_write(2'd1, 0);
        repeat (5) @(negedge clk);
        chk(!busy && nbt == base_b, "R2 zero head write", {31'b0, busy}, 0);

        // R11 completion register
        reg_write(2'd2, 32'h1234_5670);
        reg_read(2'd2, rv);
        chk(rv == 32'h1234_5670, "R11 completion readback", rv, 32'h1234_5670);

        // Sweep of single descriptors over lengths 0..12
        for (int len = 0; len <= 12; len++) begin
            bit pe;
            int p;
            pe = len[0];
            p = len % 8;
            bp_on = len[1];
            bw = 128 + len * 4;
            md = OWN | SOP | EOP | (pe ? 32'h0010_0000 : 0) | (32'(p) << 16) | 32'(len);
            put_desc(32'h100, 0, 32'(bw * 4), 32'(len), md);
            base_b = nbt; base_d = ndone; base_r = nrd;
            reg_write(2'd1, 32'h100);
            wait_idle();
            @(negedge clk);
            nb = (len + 3) / 4;
            chk(nbt - base_b == nb, "R5 beat count", 32'(nbt - base_b), 32'(nb));
            for (int i = 0; i < nb; i++) begin
                chk(bt_d[base_b + i] == fpat(bw + i), "R5 beat data", bt_d[base_b + i], fpat(bw + i));
                chk(bt_k[base_b + i] == kexp(len, i == nb - 1), "R6 byte mask",
                    32'(bt_k[base_b + i]), 32'(kexp(len, i == nb - 1)));
                chk(bt_l[base_b + i] == (i == nb - 1), "R7 last flag",
                    32'(bt_l[base_b + i]), 32'(i == nb - 1));
                chk(bt_p[base_b + i] == (pe ? {1'b1, 3'(p)} : 4'h0), "R8 port tag",
                    32'(bt_p[base_b + i]), pe ? 32'(8 + p) : 0);
            end
            chk(mem[67] == ((md & ~OWN) | EOQ), "R9 R10 write-back word", mem[67], (md & ~OWN) | EOQ);
            chk(ndone - base_d == 1, "R9 done pulses", 32'(ndone - base_d), 1);
            reg_read(2'd1, rv);
            chk(rv == 0, "R10 head cleared at tail", rv, 0);
            chk(rd_a[base_r] == 32'h100 && rd_a[base_r + 1] == 32'h104 &&
                rd_a[base_r + 2] == 32'h108 && rd_a[base_r + 3] == 32'h10C,
                "R3 fetch order", rd_a[base_r + 3], 32'h10C);
        end
        bp_on = 1'b0;

        // R4 unowned descriptor
        put_desc(32'h140, 0, 32'h200, 8, SOP | EOP | 8);
        base_b = nbt; base_d = ndone;
        reg_write(2'd1, 32'h140);
        wait_idle();
        @(negedge clk);
        chk(nbt == base_b && ndone == base_d, "R4 no beats or done", 32'(nbt - base_b), 0);
        chk(mem[83] == (SOP | EOP | 8), "R4 descriptor untouched", mem[83], SOP | EOP | 8);
        reg_read(2'd1, rv);
        chk(rv == 32'h140, "R4 head keeps address", rv, 32'h140);

        // R7 R10 three-descriptor chain
        ln_c[0] = 5; ln_c[1] = 3; ln_c[2] = 6;
        bw_c[0] = 128; bw_c[1] = 144; bw_c[2] = 160;
        md_c[0] = OWN | SOP | 5; md_c[1] = OWN | 3; md_c[2] = OWN | EOP | 6;
        put_desc(32'h100, 32'h110, 32'h200, 5, md_c[0]);
        put_desc(32'h110, 32'h120, 32'h240, 3, md_c[1]);
        put_desc(32'h120, 0, 32'h280, 6, md_c[2]);
        bp_on = 1'b1;
        base_b = nbt; base_d = ndone;
        reg_write(2'd1, 32'h100);
        wait_idle();
        @(negedge clk);
        bp_on = 1'b0;
        chk(nbt - base_b == 5, "R5 chain beat count", 32'(nbt - base_b), 5);
        begin
            int k = 0;
            for (int d = 0; d < 3; d++) begin
                nb = (ln_c[d] + 3) / 4;
                for (int i = 0; i < nb; i++) begin
                    bit fin;
                    fin = (i == nb - 1);
                    chk(bt_d[base_b + k] == fpat(bw_c[d] + i), "R5 chain data",
                        bt_d[base_b + k], fpat(bw_c[d] + i));
                    chk(bt_k[base_b + k] == kexp(ln_c[d], fin), "R6 chain mask",
                        32'(bt_k[base_b + k]), 32'(kexp(ln_c[d], fin)));
                    chk(bt_l[base_b + k] == (fin && d == 2), "R7 last only with packet end",
                        32'(bt_l[base_b + k]), 32'(fin && d == 2));
                    k++;
                end
            end
        end
        chk(mem[67] == (md_c[0] & ~OWN), "R10 first write-back no end of queue", mem[67], md_c[0] & ~OWN);
        chk(mem[71] == (md_c[1] & ~OWN), "R10 second write-back no end of queue", mem[71], md_c[1] & ~OWN);
        chk(mem[75] == ((md_c[2] & ~OWN) | EOQ), "R10 tail end of queue", mem[75], (md_c[2] & ~OWN) | EOQ);
        chk(ndone - base_d == 3, "R9 chain done pulses", 32'(ndone - base_d), 3);

        // R4 R10 chain stopping at an unowned second descriptor
        put_desc(32'h100, 32'h110, 32'h200, 4, OWN | SOP | 4);
        put_desc(32'h110, 0, 32'h240, 4, EOP | 4);
        base_b = nbt; base_d = ndone;
        reg_write(2'd1, 32'h100);
        wait_idle();
        @(negedge clk);
        chk(nbt - base_b == 1 && ndone - base_d == 1, "R4 stop after first", 32'(ndone - base_d), 1);
        reg_read(2'd1, rv);
        chk(rv == 32'h110, "R10 head follows next pointer", rv, 32'h110);
        chk(mem[71] == (EOP | 4), "R4 second untouched", mem[71], EOP | 4);
        chk(mem[67] == (SOP | 4), "R9 first write-back", mem[67], SOP | 4);

        // R2 head write while busy is ignored
        put_desc(32'h100, 0, 32'h200, 64, OWN | SOP | EOP | 64);
        put_desc(32'h130, 0, 32'h200, 4, OWN | SOP | EOP | 4);
        bp_on = 1'b1;
        base_b = nbt;
        reg_write(2'd1, 32'h100);
        repeat (6) @(negedge clk);
        reg_write(2'd1, 32'h130);
        wait_idle();
        repeat (4) @(negedge clk);
        bp_on = 1'b0;
        chk(nbt - base_b == 16 && !busy, "R2 busy head write ignored", 32'(nbt - base_b), 16);
        chk(mem[79] == (OWN | SOP | EOP | 4), "R2 second chain not run", mem[79], OWN | SOP | EOP | 4);
        reg_read(2'd2, rv);
        chk(rv == 32'h1234_5670, "R11 engine leaves completion", rv, 32'h1234_5670);

        // R13 hold under backpressure
        chk(nstall > 0 && nhold_bad == 0, "R13 beat held while stalled", 32'(nhold_bad), 0);

        // R12 soft reset in mid-packet
        put_desc(32'h100, 0, 32'h200, 200, OWN | SOP | EOP | 200);
        base_d = ndone;
        reg_write(2'd1, 32'h100);
        repeat (20) @(negedge clk);
        chk(busy, "R12 running before soft reset", {31'b0, busy}, 1);
        reg_write(2'd0, 32'h3);
        chk(!busy && !tx_valid, "R12 aborted", {busy, tx_valid}, 0);
        for (int a = 0; a < 3; a++) begin
            reg_read(2'(a), rv);
            chk(rv == 0, "R12 registers cleared", rv, 0);
        end
        repeat (5) @(negedge clk);
        chk(ndone == base_d && mem[67] == (OWN | SOP | EOP | 200), "R12 no write-back",
            mem[67], OWN | SOP | EOP | 200);

        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    end
endmodule